// File: doc/BRIEF.md
# Latch-or-Register Bus Driver

This block drives a wide data bus from one bank of storage that behaves either as a transparent latch or as an edge-triggered register. An active-low pass control picks the behaviour: while it is low the output follows the input bus at once, and while it is high the bank loads the input only when the capture clock rises. The bank then holds that value until the next rising edge.

A separate active-low drive control decides whether the bus is driven or left floating. It acts only on the output. The stored word is kept while the bus floats, and a capture can still happen in that time. The capture clock is an asynchronous input. It is brought into the system clock domain through a synchronizer, and its rising edges are detected there. High impedance is shown by an active-high drive-enable output, and the data bus is set to 'z whenever that enable is low.

Top module: `latreg_driver`

## Requirements
- R1: A synchronous active-high reset clears the stored word to zero. After reset, with pass high and drive low, `dout` reads all zeros.
- R2: `dout_en` is 1 exactly when `drive_n` is 0, in the same cycle. When `dout_en` is 0, `dout` is 'z.
- R3: `drive_n` gates only the output. A capture that occurs while `drive_n` is 1 is visible once `drive_n` returns to 0.
- R4: While `pass_n` is 0, `dout` equals `din` in the same cycle, whatever `cap_clk` does.
- R5: While `pass_n` is 1, a 0-to-1 change of `cap_clk` loads `din` into the stored word. The new value shows on `dout` by the third rising `clk` edge after the change, provided `din` stays stable over that window.
- R6: While `pass_n` is 1 and `cap_clk` is held steady high or steady low, `dout` keeps its value whatever `din` does.
- R7: While `pass_n` is 0, the stored word reloads from `din` on every `clk` edge. After `pass_n` rises, `dout` keeps the last transparent value.
- R8: A 1-to-0 change of `cap_clk` loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | W (18) | Input data bus |
| cap_clk | input | 1 | Asynchronous capture clock, rising edge active |
| pass_n | input | 1 | Transparent-path select, active low |
| drive_n | input | 1 | Output drive control, active low |
| dout | output | W (18) | Output data bus, 'z when not driven |
| dout_en | output | 1 | Drive enable, active high |

## Verification
Two functions can fall in the same cycle: a capture-clock rising edge and the output being switched off. The bench raises `cap_clk` with `drive_n` high, changes `drive_n` while the synchronizer still holds the edge, and then re-enables the bus. The capture is judged correct when the re-enabled bus shows the word that was on `din` at the capture. The handover from transparent to held mode is probed the same way: `din` changes on the cycle right after `pass_n` rises, and the bench expects the earlier word to remain.

// File: rtl/latreg_pkg.sv
package latreg_pkg;
    localparam int unsigned BUS_W      = 18;
    localparam int unsigned SYNC_DEPTH = 2;

    typedef enum logic {
        PATH_OPEN = 1'b0,
        PATH_HELD = 1'b1
    } path_mode_e;

    function automatic path_mode_e decode_mode(input logic pass_n);
        return pass_n ? PATH_HELD : PATH_OPEN;
    endfunction
endpackage

// File: rtl/cp_edge_sync.sv
module cp_edge_sync #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    localparam int unsigned LAST = DEPTH;

    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[LAST-1:0], async_in};
    end

    // chain[DEPTH-1] is the last synchronizing stage; chain[DEPTH] is its delayed copy
    assign rise = chain[LAST-1] & ~chain[LAST];
endmodule

// File: rtl/latreg_store.sv
module latreg_store
    import latreg_pkg::*;
#(
    parameter int unsigned W = BUS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  path_mode_e   mode,
    input  logic         rise,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    logic load;
    assign load = (mode == PATH_OPEN) || rise;

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= din;
    end
endmodule

// File: rtl/drive_stage.sv
module drive_stage
    import latreg_pkg::*;
#(
    parameter int unsigned W = BUS_W
) (
    input  path_mode_e   mode,
    input  logic [W-1:0] din,
    input  logic [W-1:0] q,
    input  logic         drive_n,
    output logic [W-1:0] val,
    output logic         en
);
    always_comb begin
        unique case (mode)
            PATH_OPEN: val = din;
            default:   val = q;
        endcase
    end
    assign en = ~drive_n;
endmodule

// File: rtl/latreg_driver.sv
module latreg_driver
    import latreg_pkg::*;
#(
    parameter int unsigned W     = BUS_W,
    parameter int unsigned DEPTH = SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic         cap_clk,
    input  logic         pass_n,
    input  logic         drive_n,
    output logic [W-1:0] dout,
    output logic         dout_en
);
    path_mode_e   mode;
    logic         cap_rise;
    logic [W-1:0] store_q;
    logic [W-1:0] out_val;

    assign mode = decode_mode(pass_n);

    cp_edge_sync #(.DEPTH(DEPTH)) u_sync (
        .clk(clk), .rst(rst), .async_in(cap_clk), .rise(cap_rise)
    );

    latreg_store #(.W(W)) u_store (
        .clk(clk), .rst(rst), .mode(mode), .rise(cap_rise),
        .din(din), .q(store_q)
    );

    drive_stage #(.W(W)) u_drive (
        .mode(mode), .din(din), .q(store_q), .drive_n(drive_n),
        .val(out_val), .en(dout_en)
    );

    assign dout = dout_en ? out_val : 'z;
endmodule

// File: rtl/latreg_checker.sv
module latreg_checker #(
    parameter int unsigned W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] din,
    input logic         pass_n,
    input logic         drive_n,
    input logic         dout_en,
    input logic         cap_rise,
    input logic [W-1:0] store_q
);
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> store_q == '0);

    p_enable_r2: assert property (@(posedge clk) disable iff (rst)
        dout_en != drive_n);

    p_capture_off_r3: assert property (@(posedge clk) disable iff (rst)
        (drive_n && pass_n && cap_rise) |=> store_q == $past(din));

    p_capture_r5: assert property (@(posedge clk) disable iff (rst)
        (pass_n && cap_rise) |=> store_q == $past(din));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (pass_n && !cap_rise) |=> $stable(store_q));

    p_track_r7: assert property (@(posedge clk) disable iff (rst)
        !pass_n |=> store_q == $past(din));
endmodule

bind latreg_driver latreg_checker #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .din(din), .pass_n(pass_n), .drive_n(drive_n),
    .dout_en(dout_en), .cap_rise(cap_rise), .store_q(store_q)
);

// File: tb/latreg_driver_test.sv
module latreg_driver_test;
    localparam int W = 18;
    localparam time CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic         cap_clk = 1'b0;
    logic         pass_n = 1'b1;
    logic         drive_n = 1'b0;
    logic [W-1:0] dout;
    logic         dout_en;

    int unsigned  n_chk = 0;
    int unsigned  n_bad = 0;
    bit           done = 1'b0;
    logic [W-1:0] exp_q = '0;
    int unsigned  seed_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    latreg_driver uut (
        .clk(clk), .rst(rst), .din(din), .cap_clk(cap_clk),
        .pass_n(pass_n), .drive_n(drive_n), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [W-1:0] rnd_word();
        return W'($urandom());
    endfunction

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic transparent(input logic [W-1:0] v, input bit wiggle);
        pass_n = 1'b0;
        din = v;
        #1;
        chk("R4 same-cycle", dout, v);
        if (wiggle) begin
            cap_clk = ~cap_clk; cyc(1); chk("R4 cap toggle", dout, v);
            cap_clk = ~cap_clk; cyc(1); chk("R4 cap toggle back", dout, v);
        end
        cyc(4);
        exp_q = v;
        pass_n = 1'b1;
        cyc(1);
        din = ~v;
        cyc(2);
        chk("R7 handover", dout, exp_q);
    endtask

    task automatic capture(input logic [W-1:0] v, input bit off);
        if (cap_clk) begin
            cap_clk = 1'b0;
            cyc(4);
            chk("R8 falling no load", dout, exp_q);
        end
        din = v;
        cyc(1);
        if (off) drive_n = 1'b1;
        cap_clk = 1'b1;
        cyc(1);
        if (off) begin
            n_chk++;
            if (dout_en !== 1'b0) begin
                n_bad++;
                $display("FAIL R2: dout_en got %b expected 0", dout_en);
            end
        end
        cyc(3);
        exp_q = v;
        if (off) begin
            drive_n = 1'b0;
            #1;
            chk("R3 capture while off", dout, exp_q);
        end else begin
            chk("R5 capture", dout, exp_q);
        end
    endtask

    task automatic hold_steady();
        for (int i = 0; i < 3; i++) begin
            din = rnd_word();
            cyc(1);
            chk("R6 steady hold", dout, exp_q);
        end
    endtask

    initial begin
        seed_v = $urandom(32'h5eed_1234);
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk("R1 reset zero", dout, '0);
        n_chk++;
        if (dout_en !== 1'b1) begin n_bad++; $display("FAIL R2: dout_en got %b expected 1", dout_en); end
        drive_n = 1'b1; #1;
        n_chk++;
        if (dout_en !== 1'b0) begin n_bad++; $display("FAIL R2: dout_en got %b expected 0", dout_en); end
        drive_n = 1'b0; #1;

        transparent(18'h2A5A5, 1'b1);
        capture(18'h3FFFF, 1'b0);
        hold_steady();
        capture(18'h00001, 1'b1);
        hold_steady();
        capture(18'h15555, 1'b0);
        cap_clk = 1'b0; din = rnd_word(); cyc(4);
        chk("R8 falling no load", dout, exp_q);
        hold_steady();

        for (int k = 0; k < 60; k++) begin
            case ($urandom_range(0, 3))
                0: transparent(rnd_word(), bit'($urandom_range(0, 1)));
                1: capture(rnd_word(), 1'b0);
                2: capture(rnd_word(), 1'b1);
                default: hold_steady();
            endcase
        end

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule